// File: doc/BRIEF.md
# Per-Cycle Reconfigurable 8-bit ALU Datapath

This block is an 8-bit arithmetic datapath. A small table of eight control words sets its behaviour, and external logic picks one of those words on every clock edge through a 3-bit index. The chosen word sets four things for that cycle:

- the ALU function;
- the registers that feed the two ALU operands;
- the optional shift or nibble swap applied to the ALU result;
- whether the result is ANDed with a mask register before it is stored back into an accumulator.

The same hardware can therefore act as a counter on one cycle and a shifter or comparator on the next. The host loads the table and the other registers before use.

Two accumulators hold the running values, and two data registers hold constants. All four can be written and read through a simple host port. The same host write port also loads the eight control words, an active-width register and a mask register. The active width is given as the index of the top live bit. It bounds the arithmetic, places the carry/borrow and sets where shifted bits enter and leave. Together with the mask, this allows counters and shifters narrower than 8 bits.

Top module: `dyn_alu_top`

## Requirements
- R1: After reset the accumulators, data registers, carryOut and shiftOut are 0, every control word is 0, the top-bit index is 7 and the mask is 0xFF.
- R2: On each rising edge, the control word indexed by cfgAddr decides the register update; carryOut and shiftOut update on every edge.
- R3: Control word bits [2:0] select the ALU function: 0 pass A, 1 increment, 2 decrement, 3 add, 4 subtract, 5 AND, 6 OR, 7 XOR.
- R4: Bit [3] selects operand A (0 = A0, 1 = A1); bits [5:4] select operand B (0 = D0, 1 = D1, 2 = A0, 3 = A1).
- R5: Bits [7:6] select the destination (1 = A0, 2 = A1, 0 or 3 = none); with no destination and no host write, both accumulators keep their value.
- R6: The ALU works only on bits msb..0 of its operands and its result, where msb is the top-bit index. Increment and add report carry from bit msb+1. Decrement and subtract report a borrow when A is less than B (B is 1 for decrement). Logic functions and pass-through report 0.
- R7: Bits [9:8] select the post-ALU stage: 0 none, 1 left, 2 right, 3 nibble swap. A left shift puts shiftIn into bit 0 and reports bit msb on shiftOut. A right shift puts shiftIn into bit msb and reports bit 0. Only the two shifts drive shiftOut; in the other modes it is 0.
- R8: A nibble swap exchanges bits [7:4] and [3:0] of the full 8-bit ALU result.
- R9: When bit [10] is set, the value stored is ANDed with the mask register.
- R10: Host write addresses: 0 A0, 1 A1, 2 D0, 3 D1, 4 top-bit index (low 3 bits), 5 mask, 8..15 control words 0..7. Register writes take data bits [7:0]. hostRdData shows A0, A1, D0 or D1 for hostRdAddr 0..3.
- R11: A host write to an accumulator in the same cycle as a datapath update of it wins.
- R12: Add includes carryIn as the low-order carry; the other functions ignore it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfgAddr | input | 3 | Control word index for this cycle |
| shiftIn | input | 1 | Bit entering a shift |
| carryIn | input | 1 | Low-order carry for add |
| hostWe | input | 1 | Host write strobe |
| hostAddr | input | 4 | Host write address |
| hostWrData | input | 11 | Host write data |
| hostRdAddr | input | 2 | Host read select |
| hostRdData | output | 8 | Host read data |
| acc0 | output | 8 | Accumulator A0 |
| acc1 | output | 8 | Accumulator A1 |
| carryOut | output | 1 | Registered carry/borrow of the last operation |
| shiftOut | output | 1 | Registered bit shifted out by the last operation |

## Verification
The hardest case to reach is a host write to an accumulator in the same cycle that the selected control word updates that accumulator. It is most likely to expose errors when that update is shifted, masked or narrowed by a reduced top-bit index. A random control word sequence seldom lines these up. The bench therefore loads random control words, indices and masks, and then interleaves random host writes with random cfgAddr values. On every cycle a bench-side reference model predicts both accumulators, the flags and the read port. Directed runs first force wrap at a narrow width, carry-in, both shifts, the swap, masking and the collision case.

// File: rtl/dyn_alu_pkg.sv
package dyn_alu_pkg;

  typedef enum logic [2:0] {
    FN_PASS = 3'd0, FN_INC = 3'd1, FN_DEC = 3'd2, FN_ADD = 3'd3,
    FN_SUB  = 3'd4, FN_AND = 3'd5, FN_OR  = 3'd6, FN_XOR = 3'd7
  } alu_fn_e;

  typedef enum logic [1:0] {
    SH_NONE = 2'd0, SH_LEFT = 2'd1, SH_RIGHT = 2'd2, SH_SWAP = 2'd3
  } shift_e;

  // control word, LSB = function
  typedef struct packed {
    logic       maskEn;
    shift_e     shiftMode;
    logic [1:0] dest;
    logic [1:0] selB;
    logic       selA;
    alu_fn_e    func;
  } cfg_word_t;

  localparam int CFG_W = $bits(cfg_word_t);

  // strobes from control to datapath
  typedef struct packed {
    alu_fn_e    func;
    logic       selA;
    logic [1:0] selB;
    logic       wrA0;
    logic       wrA1;
    shift_e     shiftMode;
    logic       maskEn;
  } dp_strobe_t;

endpackage

// File: rtl/dyn_alu_ctrl.sv
module dyn_alu_ctrl
  import dyn_alu_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int CFG_DEPTH = 8,
  localparam int ADDR_W   = $clog2(CFG_DEPTH),
  localparam int HADDR_W  = ADDR_W + 1,
  localparam int MSB_W    = $clog2(DATA_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  cfgAddr,
  input  logic               hostWe,
  input  logic [HADDR_W-1:0] hostAddr,
  input  logic [CFG_W-1:0]   hostWrData,
  output dp_strobe_t         strobe,
  output logic [MSB_W-1:0]   msbIdx,
  output logic [DATA_W-1:0]  limMask,
  output logic [DATA_W-1:0]  outMask
);

  cfg_word_t cfgMem [CFG_DEPTH];
  cfg_word_t curWord;

  localparam logic [HADDR_W-1:0] ADR_MSB  = HADDR_W'(4);
  localparam logic [HADDR_W-1:0] ADR_MASK = HADDR_W'(5);

  wire cfgSel = hostWe && hostAddr[HADDR_W-1];

  for (genvar gi = 0; gi < CFG_DEPTH; gi++) begin : g_cfg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cfgMem[gi] <= '0;
      else if (cfgSel && hostAddr[ADDR_W-1:0] == ADDR_W'(gi))
        cfgMem[gi] <= cfg_word_t'(hostWrData);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msbIdx  <= MSB_W'(DATA_W - 1);
      outMask <= '1;
    end else if (hostWe) begin
      if (hostAddr == ADR_MSB)  msbIdx  <= hostWrData[MSB_W-1:0];
      if (hostAddr == ADR_MASK) outMask <= hostWrData[DATA_W-1:0];
    end
  end

  always_comb begin
    for (int i = 0; i < DATA_W; i++) limMask[i] = (i <= int'(msbIdx));
  end

  assign curWord          = cfgMem[cfgAddr];
  assign strobe.func      = curWord.func;
  assign strobe.selA      = curWord.selA;
  assign strobe.selB      = curWord.selB;
  assign strobe.wrA0      = (curWord.dest == 2'd1);
  assign strobe.wrA1      = (curWord.dest == 2'd2);
  assign strobe.shiftMode = curWord.shiftMode;
  assign strobe.maskEn    = curWord.maskEn;

  // R5: one destination at most
  assert_single_dest_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strobe.wrA0, strobe.wrA1}));

  // R6: live-bit mask always has bit 0 set and is contiguous
  assert_lim_contiguous_R6: assert property (@(posedge clk) disable iff (!rst_n)
    limMask[0] && ((limMask & (limMask + 1'b1)) == '0));

endmodule

// File: rtl/dyn_alu_dp.sv
module dyn_alu_dp
  import dyn_alu_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int HADDR_W  = 4,
  localparam int MSB_W   = $clog2(DATA_W),
  localparam int HALF    = DATA_W / 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  dp_strobe_t         strobe,
  input  logic [MSB_W-1:0]   msbIdx,
  input  logic [DATA_W-1:0]  limMask,
  input  logic [DATA_W-1:0]  outMask,
  input  logic               shiftIn,
  input  logic               carryIn,
  input  logic               hostWe,
  input  logic [HADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0]  hostData,
  input  logic [1:0]         hostRdAddr,
  output logic [DATA_W-1:0]  hostRdData,
  output logic [DATA_W-1:0]  acc0,
  output logic [DATA_W-1:0]  acc1,
  output logic               carryOut,
  output logic               shiftOut
);

  logic [DATA_W-1:0] dat0, dat1;
  logic [DATA_W-1:0] opA, opB, aluRes, shRes, finRes;
  logic [DATA_W:0]   wide;
  logic              aluCarry, shBit;
  logic [MSB_W:0]    carryIdx;

  wire hostA0 = hostWe && hostAddr == HADDR_W'(0);
  wire hostA1 = hostWe && hostAddr == HADDR_W'(1);
  wire hostD0 = hostWe && hostAddr == HADDR_W'(2);
  wire hostD1 = hostWe && hostAddr == HADDR_W'(3);

  assign carryIdx = {1'b0, msbIdx} + 1'b1;

  always_comb begin
    opA = (strobe.selA ? acc1 : acc0) & limMask;
    unique case (strobe.selB)
      2'd0:    opB = dat0;
      2'd1:    opB = dat1;
      2'd2:    opB = acc0;
      default: opB = acc1;
    endcase
    opB      = opB & limMask;
    wide     = '0;
    aluCarry = 1'b0;
    unique case (strobe.func)
      FN_PASS: aluRes = opA;
      FN_INC: begin
        wide     = {1'b0, opA} + 1'b1;
        aluRes   = wide[DATA_W-1:0];
        aluCarry = wide[carryIdx];
      end
      FN_DEC: begin
        aluRes   = opA - 1'b1;
        aluCarry = (opA == '0);
      end
      FN_ADD: begin
        wide     = {1'b0, opA} + {1'b0, opB} + (DATA_W+1)'(carryIn);
        aluRes   = wide[DATA_W-1:0];
        aluCarry = wide[carryIdx];
      end
      FN_SUB: begin
        aluRes   = opA - opB;
        aluCarry = (opA < opB);
      end
      FN_AND:  aluRes = opA & opB;
      FN_OR:   aluRes = opA | opB;
      default: aluRes = opA ^ opB;
    endcase
    aluRes = aluRes & limMask;

    shBit = 1'b0;
    shRes = aluRes;
    unique case (strobe.shiftMode)
      SH_LEFT: begin
        shBit = aluRes[msbIdx];
        shRes = ((aluRes << 1) | DATA_W'(shiftIn)) & limMask;
      end
      SH_RIGHT: begin
        shBit         = aluRes[0];
        shRes         = aluRes >> 1;
        shRes[msbIdx] = shiftIn;
      end
      SH_SWAP: shRes = {aluRes[HALF-1:0], aluRes[DATA_W-1:HALF]};
      default: shRes = aluRes;
    endcase
    finRes = strobe.maskEn ? (shRes & outMask) : shRes;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc0     <= '0;
      acc1     <= '0;
      dat0     <= '0;
      dat1     <= '0;
      carryOut <= 1'b0;
      shiftOut <= 1'b0;
    end else begin
      carryOut <= aluCarry;
      shiftOut <= shBit;
      // host write overrides datapath update
      if (hostA0)           acc0 <= hostData;
      else if (strobe.wrA0) acc0 <= finRes;
      if (hostA1)           acc1 <= hostData;
      else if (strobe.wrA1) acc1 <= finRes;
      if (hostD0) dat0 <= hostData;
      if (hostD1) dat1 <= hostData;
    end
  end

  always_comb begin
    unique case (hostRdAddr)
      2'd0:    hostRdData = acc0;
      2'd1:    hostRdData = acc1;
      2'd2:    hostRdData = dat0;
      default: hostRdData = dat1;
    endcase
  end

  assert_host_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    hostA0 |=> acc0 == $past(hostData));

  assert_no_dest_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe.wrA1 && !hostA1) |=> $stable(acc1));

  assert_width_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.wrA0 && !hostA0 && strobe.shiftMode != SH_SWAP)
      |=> (acc0 & ~$past(limMask)) == '0);

  assert_mask_applied_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.wrA1 && !hostA1 && strobe.maskEn) |=> (acc1 & ~$past(outMask)) == '0);

  assert_shout_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.shiftMode == SH_NONE || strobe.shiftMode == SH_SWAP) |=> !shiftOut);

endmodule

// File: rtl/dyn_alu_top.sv
module dyn_alu_top
  import dyn_alu_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int CFG_DEPTH = 8,
  localparam int ADDR_W   = $clog2(CFG_DEPTH),
  localparam int HADDR_W  = ADDR_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  cfgAddr,
  input  logic               shiftIn,
  input  logic               carryIn,
  input  logic               hostWe,
  input  logic [HADDR_W-1:0] hostAddr,
  input  logic [CFG_W-1:0]   hostWrData,
  input  logic [1:0]         hostRdAddr,
  output logic [DATA_W-1:0]  hostRdData,
  output logic [DATA_W-1:0]  acc0,
  output logic [DATA_W-1:0]  acc1,
  output logic               carryOut,
  output logic               shiftOut
);

  localparam int MSB_W = $clog2(DATA_W);

  dp_strobe_t        strobe;
  logic [MSB_W-1:0]  msbIdx;
  logic [DATA_W-1:0] limMask, outMask;

  dyn_alu_ctrl #(.DATA_W(DATA_W), .CFG_DEPTH(CFG_DEPTH)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .cfgAddr(cfgAddr), .hostWe(hostWe),
    .hostAddr(hostAddr), .hostWrData(hostWrData), .strobe(strobe),
    .msbIdx(msbIdx), .limMask(limMask), .outMask(outMask)
  );

  dyn_alu_dp #(.DATA_W(DATA_W), .HADDR_W(HADDR_W)) dp_i (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .msbIdx(msbIdx),
    .limMask(limMask), .outMask(outMask), .shiftIn(shiftIn),
    .carryIn(carryIn), .hostWe(hostWe), .hostAddr(hostAddr),
    .hostData(hostWrData[DATA_W-1:0]), .hostRdAddr(hostRdAddr),
    .hostRdData(hostRdData), .acc0(acc0), .acc1(acc1),
    .carryOut(carryOut), .shiftOut(shiftOut)
  );

endmodule

// File: tb/dyn_alu_top_tb_top.sv
`timescale 1ns/1ps
module dyn_alu_top_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cfgAddr = '0;
  logic        shiftIn = 1'b0, carryIn = 1'b0, hostWe = 1'b0;
  logic [3:0]  hostAddr = '0;
  logic [10:0] hostWrData = '0;
  logic [1:0]  hostRdAddr = '0;
  logic [7:0]  hostRdData, acc0, acc1;
  logic        carryOut, shiftOut;

  int nChecks = 0, nFails = 0;
  bit finished = 0;

  int mReg[4];
  int mCfg[8];
  int mMsb, mMask, mCarry, mSo;

  always #2.5 clk = ~clk;

  dyn_alu_top dut_i (
    .clk(clk), .rst_n(rst_n), .cfgAddr(cfgAddr), .shiftIn(shiftIn),
    .carryIn(carryIn), .hostWe(hostWe), .hostAddr(hostAddr),
    .hostWrData(hostWrData), .hostRdAddr(hostRdAddr), .hostRdData(hostRdData),
    .acc0(acc0), .acc1(acc1), .carryOut(carryOut), .shiftOut(shiftOut)
  );

  function automatic int mk(int fn, int sa, int sb, int dst, int sh, int me);
    return fn | (sa << 3) | (sb << 4) | (dst << 6) | (sh << 8) | (me << 10);
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic modelStep(int ca, int si, int ci, int we, int wa, int wd);
    int w, lim, a, b, r, c, so, fn, sh;
    w   = mCfg[ca];
    lim = (1 << (mMsb + 1)) - 1;
    a   = (((w >> 3) & 1) ? mReg[1] : mReg[0]) & lim;
    case ((w >> 4) & 3)
      0: b = mReg[2];
      1: b = mReg[3];
      2: b = mReg[0];
      default: b = mReg[1];
    endcase
    b  = b & lim;
    fn = w & 7;
    c  = 0;
    case (fn)
      0: r = a;
      1: begin r = a + 1; c = (r >> (mMsb + 1)) & 1; end
      2: begin r = a - 1; c = (a < 1) ? 1 : 0; end
      3: begin r = a + b + ci; c = (r >> (mMsb + 1)) & 1; end
      4: begin r = a - b; c = (a < b) ? 1 : 0; end
      5: r = a & b;
      6: r = a | b;
      default: r = a ^ b;
    endcase
    r  = r & lim;
    so = 0;
    sh = (w >> 8) & 3;
    if (sh == 1) begin so = (r >> mMsb) & 1; r = ((r << 1) | si) & lim; end
    else if (sh == 2) begin so = r & 1; r = (r >> 1) | (si << mMsb); end
    else if (sh == 3) r = ((r & 15) << 4) | ((r >> 4) & 15);
    if ((w >> 10) & 1) r = r & mMask;
    case ((w >> 6) & 3)
      1: mReg[0] = r;
      2: mReg[1] = r;
      default: ;
    endcase
    mCarry = c;
    mSo    = so;
    if (we) begin
      if (wa < 4) mReg[wa] = wd & 255;
      else if (wa == 4) mMsb = wd & 7;
      else if (wa == 5) mMask = wd & 255;
      else if (wa >= 8) mCfg[wa - 8] = wd & 2047;
    end
  endtask

  task automatic step(string tag, int ca, int si, int ci, int we, int wa, int wd, int ra);
    cfgAddr = 3'(ca); shiftIn = si[0]; carryIn = ci[0];
    hostWe = we[0]; hostAddr = 4'(wa); hostWrData = 11'(wd); hostRdAddr = 2'(ra);
    modelStep(ca, si, ci, we, wa, wd);
    @(posedge clk);
    @(negedge clk);
    hostWe = 1'b0;
    chk(tag, "acc0", int'(acc0), mReg[0]);
    chk(tag, "acc1", int'(acc1), mReg[1]);
    chk(tag, "carryOut", int'(carryOut), mCarry);
    chk(tag, "shiftOut", int'(shiftOut), mSo);
    chk(tag, "hostRdData", int'(hostRdData), mReg[ra]);
  endtask

  task automatic hw(string tag, int wa, int wd);
    step(tag, 7, 0, 0, 1, wa, wd, wa & 3);
  endtask

  initial begin
    void'($urandom(32'd20240607));
    for (int i = 0; i < 4; i++) mReg[i] = 0;
    for (int i = 0; i < 8; i++) mCfg[i] = 0;
    mMsb = 7; mMask = 255; mCarry = 0; mSo = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "acc0", int'(acc0), 0);
    chk("R1", "acc1", int'(acc1), 0);
    chk("R1", "carryOut", int'(carryOut), 0);
    chk("R1", "shiftOut", int'(shiftOut), 0);
    for (int r = 0; r < 4; r++) step("R1", r, 1, 1, 0, 0, 0, r);

    // R10 host writes and readback
    hw("R10", 2, 8'h05); hw("R10", 3, 8'h30);
    hw("R10", 0, 8'h0E); hw("R10", 1, 8'hA5);

    // R6 increment wrap at 4-bit width (cfg0: inc A0 -> A0)
    hw("R6", 8, mk(1, 0, 0, 1, 0, 0));
    hw("R6", 4, 3);
    for (int i = 0; i < 3; i++) step("R6", 0, 0, 0, 0, 0, 0, 0);
    // decrement borrow below zero
    hw("R6", 9, mk(2, 0, 0, 1, 0, 0));
    for (int i = 0; i < 2; i++) step("R6", 1, 0, 0, 0, 0, 0, 0);
    hw("R6", 4, 7);

    // R12 add with carry-in; R4 operand B from D1 / A0
    hw("R12", 10, mk(3, 1, 1, 2, 0, 0));
    step("R12", 2, 0, 1, 0, 0, 0, 1);
    step("R12", 2, 0, 0, 0, 0, 0, 1);
    hw("R4", 11, mk(4, 1, 2, 2, 0, 0));
    step("R4", 3, 0, 0, 0, 0, 0, 1);

    // R7 shifts at 5-bit width
    hw("R7", 4, 4);
    hw("R7", 0, 8'h15);
    hw("R7", 12, mk(0, 0, 0, 1, 1, 0));
    hw("R7", 13, mk(0, 0, 0, 1, 2, 0));
    for (int i = 0; i < 4; i++) step("R7", 4, i & 1, 0, 0, 0, 0, 0);
    for (int i = 0; i < 4; i++) step("R7", 5, i & 1, 0, 0, 0, 0, 0);
    hw("R7", 4, 7);

    // R8 nibble swap on A1 with XOR of D0
    hw("R8", 14, mk(7, 1, 0, 2, 3, 0));
    step("R8", 6, 0, 0, 0, 0, 0, 1);
    step("R8", 6, 0, 0, 0, 0, 0, 1);

    // R9 mask on OR result
    hw("R9", 5, 8'h3C);
    hw("R9", 15, mk(6, 1, 1, 1, 0, 1));
    step("R9", 7, 0, 0, 0, 0, 0, 0);

    // R11 host write collides with datapath update to A0
    step("R11", 7, 0, 0, 1, 0, 8'h81, 0);
    step("R11", 0, 0, 0, 1, 0, 8'h42, 0);

    // R5 no destination: accumulators hold
    hw("R5", 8, mk(3, 0, 3, 3, 1, 0));
    for (int i = 0; i < 3; i++) step("R5", 0, 1, 1, 0, 0, 0, i);

    // R2/R3 random control words, widths, masks and host traffic
    for (int i = 0; i < 8; i++) hw("R3", 8 + i, int'($urandom_range(2047)));
    for (int n = 0; n < 1200; n++) begin
      int we, wa, wd;
      we = ($urandom_range(9) == 0) ? 1 : 0;
      wa = int'($urandom_range(15));
      if (wa == 6 || wa == 7) wa = 0;
      wd = int'($urandom_range(2047));
      if (wa == 4 && $urandom_range(3) != 0) wd = 7;
      step("R2", int'($urandom_range(7)), int'($urandom_range(1)),
           int'($urandom_range(1)), we, wa, wd, int'($urandom_range(3)));
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

endmodule